// File: doc/BRIEF.md
# Compressed-Mode Halfword Fetch Sequencer

This block sits between a 32-bit instruction memory read port and the instruction decoder of a processor that runs both full-width 32-bit instructions and 16-bit compressed instructions. It holds one fetched word at a time. It hands the decoder that word tagged as a full instruction, or splits it into two halfword instructions, each tagged with its position. In compressed mode one memory read feeds two instructions, so the program counter unit and the memory are used only for every other instruction.

Fetch requests circulate as a fixed number of tokens. After reset the block issues one request per cycle until a parameter-set ring depth of 2 or 3 requests is outstanding. From then on it issues exactly one new request each time a whole word has been consumed: when a full instruction or a second halfword is released to the decoder. No request follows a first halfword. The word-level mode is taken from the mode input at the moment a word is accepted. A word that enters at an odd halfword, as a redirect target does, yields only its second halfword.

Top module: `hfs_fetch_seq`

## Requirements
- R1: After reset the block presents no instruction (decoder valid low) and accepts a word (memory ready high); after reset release it raises the fetch request in each of the first DEPTH cycles when no word has arrived, and then holds it low.
- R2: A word accepted while the mode input is 0 is released once with kind code 0 (full) and the 32-bit word unchanged as the instruction.
- R3: A word accepted while the mode input is 1 (and entry flag 0) is released as two instructions in order: kind code 1 (first) carrying bits 31:16 in the low 16 bits, then kind code 2 (second) carrying bits 15:0; the upper 16 instruction bits are zero for both.
- R4: Outside the reset priming, the fetch request is high in exactly those cycles where a kind 0 or kind 2 instruction is released; releasing a kind 1 instruction never raises it.
- R5: Requests outstanding plus the held word plus the priming requests still owed always equal DEPTH; outstanding requests never exceed DEPTH, and over a stream of N words the block issues DEPTH + N requests.
- R6: The mode input is sampled only when a word is accepted; changing it while a compressed word is held does not alter the kinds or data of that word's remaining halfwords.
- R7: A word accepted in mode 1 with the odd-entry flag set is released only as its second halfword (kind 2, bits 15:0); the odd-entry flag has no effect on a word accepted in mode 0.
- R8: While the decoder holds ready low, the presented instruction and kind stay unchanged; memory ready is high exactly when no word is held or the held word's last instruction is released in that cycle, so a new word can enter with no empty cycle.
- R9: The ring depth parameter accepts only 2 or 3 and the word width only even values of at least 4; other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid_i | input | 1 | Fetched word available |
| mem_ready_o | output | 1 | Block accepts the fetched word this cycle |
| mem_word_i | input | WORD_W | Fetched instruction word |
| mem_odd_i | input | 1 | Word is entered at its second halfword (redirect to odd halfword) |
| cmode_i | input | 1 | Instruction mode for the word being accepted: 0 full, 1 compressed |
| dec_valid_o | output | 1 | Instruction presented to the decoder |
| dec_ready_i | input | 1 | Decoder takes the presented instruction |
| dec_kind_o | output | 2 | Tag: 0 full, 1 first halfword, 2 second halfword |
| dec_insn_o | output | WORD_W | Instruction bits, halfwords right-aligned and zero-extended |
| fetch_req_o | output | 1 | Request one new fetch address from the PC unit |

## Verification
The hardest case to reach from the ports is a word-completing release that lands while priming requests are still owed, together with a new word entering in that same cycle: the request count then has to come out right without a second request line. The bench reaches it by returning words from its memory model as soon as a request is outstanding, so the first word arrives and is consumed before priming has finished, while its model of owed requests predicts the request line each cycle. Mode flips during held compressed words are produced by driving the inverse of the last accepted mode whenever no word is offered, under long decoder stalls.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
   typedef enum logic [1:0] {
      HK_FULL = 2'd0,
      HK_HI   = 2'd1,
      HK_LO   = 2'd2
   } hfs_kind_e;
endpackage

// File: rtl/hfs_slot.sv
module hfs_slot
   import hfs_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_cmode,
   input  logic              in_odd,
   output logic              out_valid,
   input  logic              out_ready,
   output hfs_kind_e         out_kind,
   output logic [WORD_W-1:0] out_insn,
   output logic              word_done,
   output logic              held
);
   localparam int HALF_W = WORD_W / 2;

   logic              full_q;
   logic              cmode_q;
   logic              pos_q;
   logic [WORD_W-1:0] word_q;
   logic [HALF_W-1:0] half_w [2];
   logic              accept;
   logic              step_hi;

   // lane 0 is the first (upper) halfword: big-endian order
   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign half_w[g] = word_q[WORD_W-1-g*HALF_W -: HALF_W];
   end

   always_comb begin
      if (!cmode_q)   out_kind = HK_FULL;
      else if (pos_q) out_kind = HK_LO;
      else            out_kind = HK_HI;
   end

   always_comb begin
      unique case (out_kind)
         HK_HI:   out_insn = {{HALF_W{1'b0}}, half_w[0]};
         HK_LO:   out_insn = {{HALF_W{1'b0}}, half_w[1]};
         default: out_insn = word_q;
      endcase
   end

   assign out_valid = full_q;
   assign held      = full_q;
   assign word_done = full_q & out_ready & (out_kind != HK_HI);
   assign step_hi   = full_q & out_ready & (out_kind == HK_HI);
   assign in_ready  = ~full_q | word_done;
   assign accept    = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         cmode_q <= 1'b0;
         pos_q   <= 1'b0;
         word_q  <= '0;
      end else if (accept) begin
         full_q  <= 1'b1;
         cmode_q <= in_cmode;
         pos_q   <= in_cmode & in_odd;
         word_q  <= in_word;
      end else if (word_done) begin
         full_q  <= 1'b0;
      end else if (step_hi) begin
         pos_q   <= 1'b1;
      end
   end

   // R8: a stalled instruction does not change
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !out_ready) |=> (full_q && $stable(out_insn) && $stable(out_kind)));

   // R3: a released first halfword is followed by its second halfword
   a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && out_ready && out_kind == HK_HI) |=> (full_q && out_kind == HK_LO));

   // R6: the held word's mode cannot flip while it is presented
   a_r6_mode_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !in_ready) |=> $stable(cmode_q));
endmodule

// File: rtl/hfs_tokens.sv
module hfs_tokens #(
   parameter int DEPTH = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_done,
   input  logic             word_accept,
   output logic             fetch_req,
   output logic [CNT_W-1:0] inflight,
   output logic [CNT_W-1:0] prime_left
);
   logic [CNT_W-1:0] prime_q;
   logic [CNT_W-1:0] inflight_q;
   logic             prime_go;

   // a word-completion request takes the line; owed priming waits a cycle
   assign prime_go   = (prime_q != '0) & ~word_done;
   assign fetch_req  = word_done | (prime_q != '0);
   assign inflight   = inflight_q;
   assign prime_left = prime_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prime_q    <= CNT_W'(DEPTH);
         inflight_q <= '0;
      end else begin
         if (prime_go) prime_q <= prime_q - 1'b1;
         inflight_q <= inflight_q + CNT_W'(fetch_req) - CNT_W'(word_accept);
      end
   end

   // R5: never more fetches in flight than ring tokens
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_q <= CNT_W'(DEPTH));

   // R5: a word only arrives against an outstanding request
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      word_accept |-> (inflight_q != '0));
endmodule

// File: rtl/hfs_fetch_seq.sv
module hfs_fetch_seq
   import hfs_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_valid_i,
   output logic              mem_ready_o,
   input  logic [WORD_W-1:0] mem_word_i,
   input  logic              mem_odd_i,
   input  logic              cmode_i,
   output logic              dec_valid_o,
   input  logic              dec_ready_i,
   output logic [1:0]        dec_kind_o,
   output logic [WORD_W-1:0] dec_insn_o,
   output logic              fetch_req_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   // R9: elaboration-time parameter checks
   if (DEPTH < 2 || DEPTH > 3) begin : g_bad_depth
      $error("hfs_fetch_seq: DEPTH must be 2 or 3");
   end
   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("hfs_fetch_seq: WORD_W must be even and at least 4");
   end

   hfs_kind_e        kind;
   logic             word_done;
   logic             held;
   logic [CNT_W-1:0] inflight;
   logic [CNT_W-1:0] prime_left;

   hfs_slot #(.WORD_W(WORD_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mem_valid_i),
      .in_ready  (mem_ready_o),
      .in_word   (mem_word_i),
      .in_cmode  (cmode_i),
      .in_odd    (mem_odd_i),
      .out_valid (dec_valid_o),
      .out_ready (dec_ready_i),
      .out_kind  (kind),
      .out_insn  (dec_insn_o),
      .word_done (word_done),
      .held      (held)
   );

   hfs_tokens #(.DEPTH(DEPTH)) u_tokens (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_done   (word_done),
      .word_accept (mem_valid_i & mem_ready_o),
      .fetch_req   (fetch_req_o),
      .inflight    (inflight),
      .prime_left  (prime_left)
   );

   assign dec_kind_o = kind;

   // R5: tokens are conserved between the slot and the request counter
   a_r5_tokens: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(inflight) + 32'(held) + 32'(prime_left)) == 32'(DEPTH));

   // R4: a first halfword release never requests a fetch once primed
   a_r4_no_req_first: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid_o && dec_ready_i && kind == HK_HI && prime_left == '0) |-> !fetch_req_o);
endmodule

// File: tb/hfs_fetch_seq_tb_top.sv
module hfs_fetch_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 2;
   localparam int MAXW       = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_valid = 1'b0;
   logic        mem_ready;
   logic [31:0] mem_word = '0;
   logic        mem_odd = 1'b0;
   logic        cmode = 1'b0;
   logic        dec_valid;
   logic        dec_ready = 1'b0;
   logic [1:0]  dec_kind;
   logic [31:0] dec_insn;
   logic        fetch_req;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] words [MAXW];
   logic        modes [MAXW];
   logic        odds  [MAXW];
   logic [1:0]  ekind [2*MAXW];
   logic [31:0] einsn [2*MAXW];
   string       etag  [2*MAXW];

   always #(CLK_PERIOD/2) clk = ~clk;

   hfs_fetch_seq #(.WORD_W(32), .DEPTH(DEPTH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_valid_i (mem_valid),
      .mem_ready_o (mem_ready),
      .mem_word_i  (mem_word),
      .mem_odd_i   (mem_odd),
      .cmode_i     (cmode),
      .dec_valid_o (dec_valid),
      .dec_ready_i (dec_ready),
      .dec_kind_o  (dec_kind),
      .dec_insn_o  (dec_insn),
      .fetch_req_o (fetch_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      summary();
      $finish;
   end

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; mem_valid = 1'b0; dec_ready = 1'b0; cmode = 1'b0; mem_odd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1: reset state and priming requests
   task automatic test_reset();
      @(negedge clk);
      rst_n = 1'b0; mem_valid = 1'b0; dec_ready = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(dec_valid == 1'b0, "R1 valid in reset", 32'(dec_valid), 32'd0);
      chk(mem_ready == 1'b1, "R1 ready in reset", 32'(mem_ready), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < DEPTH + 4; k++) begin
         #1;
         chk(fetch_req == (k < DEPTH), "R1 priming request", 32'(fetch_req), 32'(k < DEPTH));
         chk(dec_valid == 1'b0, "R1 idle decoder", 32'(dec_valid), 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic run_stream(input string ctag, input int n, input int rd_per, input int rd_low,
                             input int gap_per, input int gap_low);
      int nexp = 0;
      int idx = 0, rel = 0, reqs = 0, done = 0, outst = 0, cyc = 0;
      logic last_mode = 1'b0;
      bit stall_prev = 0;
      logic [1:0] pk = '0;
      logic [31:0] pi = '0;
      for (int i = 0; i < n; i++) begin
         if (!modes[i]) begin
            ekind[nexp] = 2'd0; einsn[nexp] = words[i];
            etag[nexp] = odds[i] ? "R7 odd ignored full" : "R2 full";
            nexp++;
         end else if (odds[i]) begin
            ekind[nexp] = 2'd2; einsn[nexp] = {16'h0, words[i][15:0]};
            etag[nexp] = "R7 odd entry"; nexp++;
         end else begin
            ekind[nexp] = 2'd1; einsn[nexp] = {16'h0, words[i][31:16]}; etag[nexp] = ctag; nexp++;
            ekind[nexp] = 2'd2; einsn[nexp] = {16'h0, words[i][15:0]};  etag[nexp] = ctag; nexp++;
         end
      end
      apply_reset();
      while ((rel < nexp || idx < n) && cyc < 3000) begin
         bit have, rls, dn, exp_req;
         have = (idx < n) && (outst > 0) && !(gap_per > 0 && (cyc % gap_per) < gap_low);
         mem_valid = have;
         mem_word  = have ? words[idx] : 32'hDEADBEEF;
         cmode     = have ? modes[idx] : ~last_mode;
         mem_odd   = have ? odds[idx] : 1'b1;
         dec_ready = !(rd_per > 0 && (cyc % rd_per) < rd_low);
         #1;
         if (stall_prev) begin
            chk(dec_valid == 1'b1, "R8 stall valid", 32'(dec_valid), 32'd1);
            chk(dec_kind == pk, "R8 stall kind", 32'(dec_kind), 32'(pk));
            chk(dec_insn == pi, "R8 stall insn", dec_insn, pi);
         end
         rls = dec_valid && dec_ready;
         dn = 0;
         if (rls) begin
            if (rel < nexp) begin
               chk(dec_kind == ekind[rel], {etag[rel], " kind"}, 32'(dec_kind), 32'(ekind[rel]));
               chk(dec_insn == einsn[rel], {etag[rel], " insn"}, dec_insn, einsn[rel]);
               dn = (ekind[rel] != 2'd1);
            end else begin
               chk(1'b0, "R2 extra release", 32'(rel), 32'(nexp));
            end
            rel++;
         end
         chk(mem_ready == (!dec_valid || dn), "R8 mem ready", 32'(mem_ready), 32'(!dec_valid || dn));
         exp_req = (reqs < DEPTH + done) ? 1'b1 : dn;
         chk(fetch_req == exp_req, "R4 fetch request", 32'(fetch_req), 32'(exp_req));
         if (mem_valid && mem_ready) begin
            idx++; outst--; last_mode = cmode;
         end
         if (fetch_req) begin reqs++; outst++; end
         if (dn) done++;
         chk(outst <= DEPTH, "R5 outstanding bound", 32'(outst), 32'(DEPTH));
         stall_prev = dec_valid && !dec_ready;
         pk = dec_kind; pi = dec_insn;
         @(negedge clk);
         cyc++;
      end
      chk(cyc < 3000, "R5 stream hung", 32'(cyc), 32'd3000);
      chk(rel == nexp, "R3 instructions emitted", 32'(rel), 32'(nexp));
      chk(reqs == DEPTH + n, "R5 requests per word", 32'(reqs), 32'(DEPTH + n));
      chk(outst == DEPTH, "R5 ring refilled", 32'(outst), 32'(DEPTH));
      mem_valid = 1'b0;
   endtask

   task automatic test_full_stream();
      for (int i = 0; i < 8; i++) begin
         words[i] = 32'hA5000001 ^ (i * 32'h01030507); modes[i] = 1'b0; odds[i] = 1'b0;
      end
      run_stream("R2 full", 8, 0, 0, 0, 0);
   endtask

   task automatic test_compressed_stream();
      for (int i = 0; i < 8; i++) begin
         words[i] = 32'h3C5A0F00 + (i * 32'h11112223); modes[i] = 1'b1; odds[i] = 1'b0;
      end
      run_stream("R3 compressed", 8, 3, 1, 0, 0);
   endtask

   task automatic test_mixed_odd();
      for (int i = 0; i < 12; i++) begin
         words[i] = 32'h7E810000 ^ (i * 32'h0F1E2D3C);
         modes[i] = (i % 3) != 0;
         odds[i]  = (i % 4) == 1 || (i % 4) == 3;
      end
      run_stream("R3 mixed", 12, 5, 2, 0, 0);
   endtask

   task automatic test_mode_hold();
      for (int i = 0; i < 6; i++) begin
         words[i] = 32'hC0DE0000 | (i * 32'h00010203) | (i << 20); modes[i] = 1'b1; odds[i] = 1'b0;
      end
      run_stream("R6 mode held", 6, 9, 6, 4, 3);
   endtask

   task automatic test_backpressure();
      for (int i = 0; i < 10; i++) begin
         words[i] = 32'h12345678 + (i * 32'h9ABCDEF1); modes[i] = i[0]; odds[i] = (i == 4);
      end
      run_stream("R8 backpressure", 10, 4, 2, 3, 1);
   endtask

   initial begin
      test_reset();
      test_full_stream();
      test_compressed_stream();
      test_mixed_odd();
      test_mode_hold();
      test_backpressure();
      summary();
      $finish;
   end
endmodule